// File: doc/BRIEF.md
# SIMD Lane Shuffle Network

This block moves 32-bit values between the lanes of a 32-lane SIMD group in a single operation. Every lane presents a value, and every lane receives the value of one source lane. The source is chosen by one of four addressing modes. In indexed mode each lane names its source lane. In up and down modes all lanes shift by a shared distance. In XOR mode each lane swaps with a partner whose number is its own number XORed with a shared pattern.

A segment width, which must be a power of two, splits the group into independent sub-groups. Addressing never crosses a sub-group edge. A participation mask marks the lanes that take part. An active lane whose source is outside the mask keeps its own value and raises a per-lane flag.

Results are registered. An operation accepted on one clock edge is presented after that edge. Both sides use a valid/ready handshake, and a single output register provides the back-pressure.

Top module: `lane_shuffle`

## Requirements
- R1: Mode 0 (indexed): active lane i with legal width W receives the value of lane `base + (srcIdx_i mod W)`, where `base = i - (i mod W)` and srcIdx_i is bits [5i+4:5i] of `inSrcIdx`. Lane i data sits at bits [32i+31:32i] of `inData` and `outData`.
- R2: Mode 1 (up): active lane i receives the value of lane `i - d`, where d is `inShiftArg`. If `(i mod W) < d`, the lane receives its own value, and this does not raise its flag.
- R3: Mode 2 (down): active lane i receives the value of lane `i + d`. If `(i mod W) + d >= W`, the lane receives its own value, and this does not raise its flag.
- R4: Mode 3 (XOR): active lane i receives the value of lane `base + (((i mod W) XOR m) mod W)`, where m is `inShiftArg`. A pattern of zero returns every value unchanged.
- R5: Addressing is confined to aligned sub-groups of W lanes for every W in {1, 2, 4, 8, 16, 32}. With W = 1, every lane receives its own value.
- R6: A lane whose bit in `inPartMask` is 0 receives its own input value, and its `outFallback` bit is 0.
- R7: An active lane whose computed source lane has a 0 mask bit receives its own input value, and its `outFallback` bit is 1.
- R8: A width outside {1, 2, 4, 8, 16, 32} sets `outWidthErr`. In that case every lane receives its own value and all `outFallback` bits are 0. A legal width clears `outWidthErr`.
- R9: A result is presented on `outData` and `outValid` right after the clock edge that accepts the input (`inValid && inReady`). `outValid` falls after a transfer that is not followed by a new accept.
- R10: While `outValid` is 1 and `outReady` is 0, `inReady` is 0 and the outputs stay unchanged.
- R11: After reset, `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation can be taken |
| inData | input | LANES*DATA_W | Lane values, lane i at [DATA_W*i +: DATA_W] |
| inMode | input | 2 | 0 indexed, 1 up, 2 down, 3 XOR |
| inSrcIdx | input | LANES*IDX_W | Per-lane source operand for indexed mode |
| inShiftArg | input | IDX_W | Shift distance (up/down) or XOR pattern |
| inPartMask | input | LANES | Participation mask, 1 = lane takes part |
| inSegWidth | input | IDX_W+1 | Sub-group width |
| outValid | output | 1 | Result held |
| outReady | input | 1 | Result consumed |
| outData | output | LANES*DATA_W | Shuffled lane values |
| outFallback | output | LANES | Per-lane flag: source lane was inactive |
| outWidthErr | output | 1 | Width operand was illegal |

## Verification
Every lane carries a distinct value, so a wrong source lane shows up directly in the output.

- **Indexed mode:** tried with a full reversal and with out-of-range indices at a narrow width. This separates the modulo reduction from the segment-base offset.
- **Up and down shifts:** tried at full and narrow widths, with distances that straddle segment edges. This tells clamping at a segment edge apart from wraparound into the neighbouring segment.
- **XOR mode:** tried with a zero pattern and with a pattern wider than the segment.
- **Sparse participation masks:** tell a lane's own inactivity apart from an inactive source, which are the only two cases that differ in the flag.
- **Illegal widths and handshake:** illegal widths and a stalling consumer check the error pass-through and that results are held under back-pressure.

// File: rtl/lane_shuffle_pkg.sv
package lane_shuffle_pkg;

  typedef enum logic [1:0] {
    MODE_INDEX = 2'd0,
    MODE_UP    = 2'd1,
    MODE_DOWN  = 2'd2,
    MODE_XOR   = 2'd3
  } shuffleMode_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic load;
  } shuffleStrobe_t;

endpackage

// File: rtl/shuffle_lane_addr.sv
module shuffle_lane_addr
  import lane_shuffle_pkg::*;
#(
  parameter int LANES = 32,
  parameter int LANE  = 0,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WID_W = IDX_W + 1
) (
  input  shuffleMode_t     mode,
  input  logic [IDX_W-1:0] srcOperand,
  input  logic [IDX_W-1:0] shiftArg,
  input  logic [IDX_W-1:0] relMask,
  input  logic [WID_W-1:0] segWidth,
  output logic [IDX_W-1:0] srcLane,
  output logic             keepOwn
);

  localparam logic [IDX_W-1:0] SELF = IDX_W'(LANE);

  logic [IDX_W-1:0] segBase;
  logic [IDX_W-1:0] relIdx;
  logic [WID_W:0]   downReach;

  assign segBase   = SELF & ~relMask;
  assign relIdx    = SELF & relMask;
  assign downReach = {{(WID_W + 1 - IDX_W){1'b0}}, relIdx}
                   + {{(WID_W + 1 - IDX_W){1'b0}}, shiftArg};

  always_comb begin
    srcLane = SELF;
    keepOwn = 1'b0;
    unique case (mode)
      MODE_INDEX: srcLane = segBase | (srcOperand & relMask);
      MODE_UP: begin
        if (relIdx < shiftArg) keepOwn = 1'b1;
        else                   srcLane = SELF - shiftArg;
      end
      MODE_DOWN: begin
        if (downReach >= {1'b0, segWidth}) keepOwn = 1'b1;
        else                               srcLane = SELF + shiftArg;
      end
      MODE_XOR: srcLane = segBase | ((relIdx ^ shiftArg) & relMask);
      default: srcLane = SELF;
    endcase
  end

endmodule

// File: rtl/shuffle_ctrl.sv
module shuffle_ctrl
  import lane_shuffle_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  input  logic           outReady,
  output logic           inReady,
  output logic           outValid,
  output shuffleStrobe_t strobe
);

  logic validQ;

  assign inReady     = !validQ || outReady;
  assign strobe.load = inValid && inReady;
  assign outValid    = validQ;

  always_ff @(posedge clk) begin
    if (!rstN)            validQ <= 1'b0;
    else if (strobe.load) validQ <= 1'b1;
    else if (outReady)    validQ <= 1'b0;
  end

endmodule

// File: rtl/shuffle_datapath.sv
module shuffle_datapath
  import lane_shuffle_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WID_W = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  shuffleStrobe_t          strobe,
  input  logic [LANES*DATA_W-1:0] inData,
  input  shuffleMode_t            inMode,
  input  logic [LANES*IDX_W-1:0]  inSrcIdx,
  input  logic [IDX_W-1:0]        inShiftArg,
  input  logic [LANES-1:0]        inPartMask,
  input  logic [WID_W-1:0]        inSegWidth,
  output logic [LANES*DATA_W-1:0] outData,
  output logic [LANES-1:0]        outFallback,
  output logic                    outWidthErr
);

  logic                    widthOk;
  logic [IDX_W-1:0]        relMask;
  logic [WID_W-1:0]        widthLess1;
  logic [LANES*DATA_W-1:0] nextData;
  logic [LANES-1:0]        nextFallback;

  assign widthLess1 = inSegWidth - WID_W'(1);
  assign widthOk    = (inSegWidth != '0)
                   && ((inSegWidth & widthLess1) == '0)
                   && (inSegWidth <= WID_W'(LANES));
  assign relMask    = widthOk ? widthLess1[IDX_W-1:0] : '0;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [IDX_W-1:0] srcLane;
    logic             keepOwn;
    logic             srcActive;
    logic             laneActive;
    logic             useOwn;

    shuffle_lane_addr #(.LANES(LANES), .LANE(g)) uAddr (
      .mode      (inMode),
      .srcOperand(inSrcIdx[g*IDX_W +: IDX_W]),
      .shiftArg  (inShiftArg),
      .relMask   (relMask),
      .segWidth  (inSegWidth),
      .srcLane   (srcLane),
      .keepOwn   (keepOwn)
    );

    assign laneActive = inPartMask[g];
    assign srcActive  = inPartMask[srcLane];
    assign useOwn     = !widthOk || !laneActive || keepOwn || !srcActive;

    assign nextFallback[g] = widthOk && laneActive && !keepOwn && !srcActive;
    assign nextData[g*DATA_W +: DATA_W] =
      useOwn ? inData[g*DATA_W +: DATA_W] : inData[srcLane*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outData     <= '0;
      outFallback <= '0;
      outWidthErr <= 1'b0;
    end else if (strobe.load) begin
      outData     <= nextData;
      outFallback <= nextFallback;
      outWidthErr <= !widthOk;
    end
  end

endmodule

// File: rtl/lane_shuffle.sv
module lane_shuffle
  import lane_shuffle_pkg::*;
#(
  parameter int LANES  = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WID_W = IDX_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [LANES*DATA_W-1:0] inData,
  input  logic [1:0]              inMode,
  input  logic [LANES*IDX_W-1:0]  inSrcIdx,
  input  logic [IDX_W-1:0]        inShiftArg,
  input  logic [LANES-1:0]        inPartMask,
  input  logic [WID_W-1:0]        inSegWidth,
  output logic                    outValid,
  input  logic                    outReady,
  output logic [LANES*DATA_W-1:0] outData,
  output logic [LANES-1:0]        outFallback,
  output logic                    outWidthErr
);

  shuffleStrobe_t strobe;

  shuffle_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  shuffle_datapath #(.LANES(LANES), .DATA_W(DATA_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inData     (inData),
    .inMode     (shuffleMode_t'(inMode)),
    .inSrcIdx   (inSrcIdx),
    .inShiftArg (inShiftArg),
    .inPartMask (inPartMask),
    .inSegWidth (inSegWidth),
    .outData    (outData),
    .outFallback(outFallback),
    .outWidthErr(outWidthErr)
  );

endmodule

// File: rtl/lane_shuffle_checker.sv
module lane_shuffle_checker #(
  parameter int LANES  = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WID_W = IDX_W + 1
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    inValid,
  input logic                    inReady,
  input logic [LANES*DATA_W-1:0] inData,
  input logic [1:0]              inMode,
  input logic [IDX_W-1:0]        inShiftArg,
  input logic [LANES-1:0]        inPartMask,
  input logic [WID_W-1:0]        inSegWidth,
  input logic                    outValid,
  input logic                    outReady,
  input logic [LANES*DATA_W-1:0] outData,
  input logic [LANES-1:0]        outFallback,
  input logic                    outWidthErr
);

  logic accepted;
  logic legalWidth;

  assign accepted = inValid && inReady;

  always_comb begin
    legalWidth = 1'b0;
    for (int k = 0; k <= IDX_W; k++) begin
      if ((1 << k) <= LANES && inSegWidth == WID_W'(1 << k)) legalWidth = 1'b1;
    end
  end

  // R10: no intake while a result waits
  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |-> !inReady);

  // R10: a waiting result is held unchanged
  assert_stall_holds_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outFallback)
                              && $stable(outWidthErr));

  // R9: accept is followed by a presented result
  assert_accept_presents_R9: assert property (@(posedge clk) disable iff (!rstN)
    accepted |=> outValid);

  // R9: drained and no new accept leaves the output empty
  assert_drain_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outReady && !accepted |=> !outValid);

  // R8: illegal width passes every lane through and flags the error
  assert_bad_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    accepted && !legalWidth |=> outWidthErr && (outFallback == '0)
                                && (outData == $past(inData)));

  // R4: XOR with a zero pattern over a full mask is the identity
  assert_xor_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    accepted && legalWidth && inMode == 2'd3 && inShiftArg == '0 && (&inPartMask)
    |=> !outWidthErr && (outData == $past(inData)) && (outFallback == '0));

  // R6: a non-participating lane keeps its value with its flag low
  for (genvar g = 0; g < LANES; g++) begin : gInactive
    assert_inactive_lane_R6: assert property (@(posedge clk) disable iff (!rstN)
      accepted && !inPartMask[g]
      |=> (outData[g*DATA_W +: DATA_W] == $past(inData[g*DATA_W +: DATA_W]))
          && !outFallback[g]);
  end

endmodule

bind lane_shuffle lane_shuffle_checker #(.LANES(LANES), .DATA_W(DATA_W)) uChecker (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .inData     (inData),
  .inMode     (inMode),
  .inShiftArg (inShiftArg),
  .inPartMask (inPartMask),
  .inSegWidth (inSegWidth),
  .outValid   (outValid),
  .outReady   (outReady),
  .outData    (outData),
  .outFallback(outFallback),
  .outWidthErr(outWidthErr)
);

// File: tb/tb_lane_shuffle.sv
module tb_lane_shuffle;

  localparam int LANES = 32;
  localparam int DW    = 32;
  localparam int IW    = 5;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 inValid = 1'b0;
  logic                 inReady;
  logic [LANES*DW-1:0]  inData = '0;
  logic [1:0]           inMode = '0;
  logic [LANES*IW-1:0]  inSrcIdx = '0;
  logic [IW-1:0]        inShiftArg = '0;
  logic [LANES-1:0]     inPartMask = '1;
  logic [IW:0]          inSegWidth = 6'd32;
  logic                 outValid;
  logic                 outReady = 1'b1;
  logic [LANES*DW-1:0]  outData;
  logic [LANES-1:0]     outFallback;
  logic                 outWidthErr;

  typedef struct {
    logic [LANES*DW-1:0] d;
    logic [LANES-1:0]    f;
    logic                e;
    string               tag;
  } item_t;

  item_t expQ[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit holdReady = 0;
  bit stallMode = 0;
  logic [LANES*IW-1:0] srcPat;

  always #5 clk = ~clk;

  lane_shuffle dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inMode(inMode), .inSrcIdx(inSrcIdx),
    .inShiftArg(inShiftArg), .inPartMask(inPartMask), .inSegWidth(inSegWidth),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .outFallback(outFallback), .outWidthErr(outWidthErr)
  );

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic check_bit(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic model(input logic [LANES*DW-1:0] d, input int mode,
                       input logic [LANES*IW-1:0] sIdx, input int arg,
                       input logic [LANES-1:0] msk, input int w,
                       output item_t it);
    bit good;
    good = (w == 1 || w == 2 || w == 4 || w == 8 || w == 16 || w == 32);
    it.e = !good;
    it.f = '0;
    for (int i = 0; i < LANES; i++) begin
      int src, base, rel;
      it.d[i*DW +: DW] = d[i*DW +: DW];
      if (good && msk[i]) begin
        base = (i / w) * w;
        rel  = i % w;
        case (mode)
          0: src = base + (int'(sIdx[i*IW +: IW]) % w);
          1: src = (rel < arg) ? i : i - arg;
          2: src = (rel + arg >= w) ? i : i + arg;
          default: src = base + ((rel ^ arg) % w);
        endcase
        if (!msk[src]) it.f[i] = 1'b1;
        else           it.d[i*DW +: DW] = d[src*DW +: DW];
      end
    end
  endtask

  function automatic logic [LANES*DW-1:0] make_data(int seed);
    logic [LANES*DW-1:0] v;
    for (int i = 0; i < LANES; i++)
      v[i*DW +: DW] = {8'(seed), 8'h5A, 16'(i * 257 + seed)};
    return v;
  endfunction

  // Driver: offers one operation and records its expected result
  task automatic send(int mode, int arg, int w, logic [LANES-1:0] msk,
                      int seed, string tag);
    item_t it;
    @(negedge clk);
    inData     = make_data(seed);
    inMode     = 2'(mode);
    inSrcIdx   = srcPat;
    inShiftArg = IW'(arg);
    inPartMask = msk;
    inSegWidth = 6'(w);
    inValid    = 1'b1;
    model(inData, mode, srcPat, arg, msk, w, it);
    it.tag = tag;
    forever begin
      #1;
      if (inReady) break;
      @(negedge clk);
    end
    @(posedge clk);
    expQ.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // Monitor: pops and compares every transferred result
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      outReady = holdReady ? 1'b0 : (stallMode ? (cyc % 3 != 2) : 1'b1);
      #2;
      if (rstN && outValid && outReady) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL R9 unexpected result actual=%h expected=none", outData[31:0]);
        end else begin
          item_t it;
          it = expQ.pop_front();
          if (outData !== it.d || outFallback !== it.f || outWidthErr !== it.e) begin
            errors++;
            $display("FAIL %s actual data=%h flags=%h err=%b expected data=%h flags=%h err=%b",
                     it.tag, outData, outFallback, outWidthErr, it.d, it.f, it.e);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [LANES*DW-1:0] held;
    for (int i = 0; i < LANES; i++) srcPat[i*IW +: IW] = IW'(i);
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    check_bit("R11 outValid in reset", outValid, 1'b0);
    check_bit("R11 inReady in reset", inReady, 1'b1);
    rstN = 1'b1;
    @(negedge clk); #3;
    check_bit("R11 outValid after reset", outValid, 1'b0);

    // R9: latency
    send(0, 0, 32, '1, 1, "R1 indexed identity");
    @(negedge clk); #3;
    check_bit("R9 outValid after accept", outValid, 1'b1);
    inValid = 1'b0;
    @(negedge clk); #3;
    check_bit("R9 outValid after drain", outValid, 1'b0);

    // R1: full reversal and out-of-range indices at narrow width
    for (int i = 0; i < LANES; i++) srcPat[i*IW +: IW] = IW'(31 - i);
    send(0, 0, 32, '1, 2, "R1 indexed reverse");
    for (int i = 0; i < LANES; i++) srcPat[i*IW +: IW] = IW'(i + 5);
    send(0, 0, 8, '1, 3, "R1 R5 indexed width 8");
    // R2 up
    send(1, 3, 32, '1, 4, "R2 up d3 w32");
    send(1, 1, 4, '1, 5, "R2 R5 up d1 w4");
    send(1, 9, 8, '1, 6, "R2 up d beyond width");
    // R3 down
    send(2, 2, 32, '1, 7, "R3 down d2 w32");
    send(2, 5, 8, '1, 8, "R3 R5 down d5 w8");
    // R4 xor
    send(3, 1, 32, '1, 9, "R4 xor 1 w32");
    send(3, 19, 4, '1, 10, "R4 R5 xor wide pattern w4");
    send(3, 0, 16, '1, 11, "R4 xor zero");
    // R5 width 1 and 2
    send(3, 31, 1, '1, 12, "R5 width 1");
    send(1, 1, 2, '1, 13, "R5 up width 2");
    // R6 R7 masks
    send(1, 1, 32, ~32'h8888_8888, 14, "R6 R7 up sparse mask");
    send(3, 2, 8, 32'h0F0F_00FF, 15, "R6 R7 xor sparse mask");
    send(0, 0, 16, 32'h0000_FFFF, 16, "R6 R7 indexed half mask");
    // R8 illegal widths
    send(1, 1, 6, '1, 17, "R8 width 6");
    send(0, 0, 0, '1, 18, "R8 width 0");
    send(2, 1, 33, '1, 19, "R8 width 33");
    send(2, 1, 16, '1, 20, "R8 legal width clears error");
    idle();
    repeat (3) @(negedge clk);

    // R10 back-pressure
    holdReady = 1;
    send(2, 3, 32, '1, 21, "R10 held result");
    @(negedge clk); #3;
    check_bit("R10 inReady low while held", inReady, 1'b0);
    held = outData;
    repeat (3) @(negedge clk);
    #3;
    check_bit("R10 outValid held", outValid, 1'b1);
    check_bit("R10 data stable while held", outData === held, 1'b1);
    holdReady = 0;
    send(3, 7, 32, '1, 22, "R10 after release");
    idle();

    // Stalling stream
    stallMode = 1;
    for (int k = 0; k < 12; k++) begin
      for (int i = 0; i < LANES; i++) srcPat[i*IW +: IW] = IW'(i * 7 + k);
      send(k % 4, k + 1, 1 << (k % 6), 32'hFFFF_FFFF ^ (32'h1 << k), 30 + k,
           "R10 stalled stream");
    end
    idle();
    for (int t = 0; t < 200 && expQ.size() != 0; t++) @(negedge clk);
    repeat (2) @(negedge clk);
    check_bit("R9 all results delivered", expQ.size() == 0, 1'b1);
    finish_run();
  end

endmodule